// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block turns already-synchronized general-purpose input pins into interrupt status bits. Each pin has its own detection lane. The lane's configuration inputs choose four things: whether detection is armed at all, whether the lane is edge- or level-sensitive, which polarity counts as active, and, if the build allows it, whether both transitions count. In edge mode the status bit latches and holds until a per-lane clear strobe drops it. In level mode the status bit follows the polarity-adjusted pin and cannot be cleared while the level is active.

The lanes are replicated across a bank. Their status bits form the vector that a surrounding register file reads and masks. Register decode, masking and input filtering belong to that surrounding logic.

All inputs are plain control pins with no handshake. Every status change becomes visible one clock edge after the input condition that causes it. Reset is synchronous and active-low. While reset is asserted, the previous-sample register of each lane loads the live pin, so a pin that is already high at release does not look like an edge.

Top module: `pin_irq_detect`

## Requirements
- R1: While `rst_n` is 0 at a clock edge, `status_o` is all zeros after that edge. A lane is not set by the first edge after reset unless the pin changes after release.
- R2: A lane whose `irq_mode_i` bit is 0 shows status 0 after the next clock edge, whatever its pin does.
- R3: In edge mode (`edge_sel_i`=1) with both-edge off and `neg_pol_i`=0, a 0-to-1 pin change sets status one edge later. With `neg_pol_i`=1, a 1-to-0 change sets it instead. The opposite transition sets nothing.
- R4: A latched edge status stays 1 while `clr_i` is 0, even after the pin returns to its idle value.
- R5: A `clr_i` bit of 1 drops a latched edge status one edge later. If a qualifying edge arrives in the same cycle as the clear, the status stays 1.
- R6: With parameter `BOTH_EDGE_EN`=1 and `both_sel_i`=1 in edge mode, both pin transitions set status, for either value of `neg_pol_i`.
- R7: With `BOTH_EDGE_EN`=0, `both_sel_i` has no effect: the lane behaves as a single-edge lane selected by `neg_pol_i`.
- R8: In level mode (`edge_sel_i`=0), status after each edge equals pin XOR `neg_pol_i` sampled at that edge. `clr_i` has no effect.
- R9: Any change of a lane's mode, edge/level, polarity or (when enabled) both-edge bit clears its status at the next edge. Reconfiguring over a steady pin never creates an edge.
- R10: Lanes are independent: one lane's pin, configuration and clear never change another lane's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | LANES | Synchronized pin levels |
| irq_mode_i | input | LANES | 1 arms detection on the lane |
| edge_sel_i | input | LANES | 1 edge-sensitive, 0 level-sensitive |
| neg_pol_i | input | LANES | 0 rising/high active, 1 falling/low active |
| both_sel_i | input | LANES | 1 selects both transitions (edge mode, if built in) |
| clr_i | input | LANES | Per-lane clear strobe for latched edge status |
| status_o | output | LANES | Interrupt status bits |

## Verification
A previous-sample register that loads the wrong value shows up as a missing or spurious status bit on `status_o`. The fault appears on the edge right after the pin transition, or right after a reconfiguration over a steady pin. A corrupted latch shows as a bit that decays with the pin, or that survives a clear, within one cycle of the event. A wrong clear/set priority shows only when a clear and a qualifying edge arrive in the same cycle, so the stimulus places them together on purpose. A fault in the build-time both-edge gating shows as a mismatch between the two parameter variants, which receive identical inputs.

// File: rtl/pid_pkg.sv
package pid_pkg;

  typedef struct packed {
    logic irq_on;
    logic edge_mode;
    logic neg_pol;
    logic both_edge;
  } pid_cfg_t;

  // Drop the both-edge bit when the build does not offer it.
  function automatic pid_cfg_t pid_norm(pid_cfg_t c, bit both_ok);
    pid_cfg_t r;
    r = c;
    r.both_edge = c.both_edge & both_ok;
    return r;
  endfunction

endpackage

// File: rtl/pid_cfg_watch.sv
module pid_cfg_watch
  import pid_pkg::*;
#(
  parameter bit BOTH_EDGE_EN = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pid_cfg_t cfg_i,
  output pid_cfg_t cfg_o,
  output logic     chg_o
);

  pid_cfg_t cfg_n;
  pid_cfg_t cfg_q;

  assign cfg_n = pid_norm(cfg_i, BOTH_EDGE_EN);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  assign cfg_o = cfg_n;
  assign chg_o = (cfg_n != cfg_q);

  // R9: a change flag is raised only when the applied configuration moves
  p_chg_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |=> (cfg_q == $past(cfg_n)));

endmodule

// File: rtl/pid_edge_det.sv
module pid_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic neg_pol_i,
  input  logic both_i,
  output logic hit_o,
  output logic level_o
);

  logic prev_q;
  logic rise;
  logic fall;

  // The previous sample always holds the raw pin, also during reset, so
  // polarity changes or reset release never fabricate a transition.
  always_ff @(posedge clk) begin
    prev_q <= pin_i;
  end

  assign rise    = pin_i & ~prev_q;
  assign fall    = ~pin_i & prev_q;
  assign level_o = pin_i ^ neg_pol_i;

  always_comb begin
    if (both_i)         hit_o = rise | fall;
    else if (neg_pol_i) hit_o = fall;
    else                hit_o = rise;
  end

  // R3: a steady pin never produces a hit
  p_steady_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pin_i) |-> !hit_o);

endmodule

// File: rtl/pid_lane.sv
module pid_lane
  import pid_pkg::*;
#(
  parameter bit BOTH_EDGE_EN = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_i,
  input  pid_cfg_t cfg_i,
  input  logic     clr_i,
  output logic     status_o
);

  pid_cfg_t cfg_eff;
  logic     cfg_chg;
  logic     hit;
  logic     lvl;
  logic     st_q;
  logic     st_d;

  pid_cfg_watch #(.BOTH_EDGE_EN(BOTH_EDGE_EN)) u_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg_i (cfg_i),
    .cfg_o (cfg_eff),
    .chg_o (cfg_chg)
  );

  pid_edge_det u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .neg_pol_i (cfg_eff.neg_pol),
    .both_i    (cfg_eff.both_edge),
    .hit_o     (hit),
    .level_o   (lvl)
  );

  always_comb begin
    if (!cfg_eff.irq_on || cfg_chg) st_d = 1'b0;
    else if (!cfg_eff.edge_mode)    st_d = lvl;
    else                            st_d = hit | (st_q & ~clr_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= st_d;
  end

  assign status_o = st_q;

  // R2: disarmed lane reads zero
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.irq_on |=> !status_o);

  // R8: level mode follows the adjusted pin, clear ignored
  p_level_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.irq_on && !cfg_i.edge_mode && !cfg_chg)
      |=> (status_o == $past(pin_i ^ cfg_i.neg_pol)));

  // R4: latched edge status holds without a clear
  p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.irq_on && cfg_i.edge_mode && !cfg_chg && !clr_i && status_o)
      |=> status_o);

  // R5: clear without a transition drops the status
  p_clr_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.edge_mode && clr_i && $stable(pin_i)) |=> !status_o);

  // R5: a transition in the clear cycle wins (single rising-edge case)
  p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.irq_on && cfg_i.edge_mode && !cfg_i.neg_pol && !cfg_chg && $rose(pin_i))
      |=> status_o);

  // R9: reconfiguration clears the lane
  p_cfg_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !status_o);

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pid_pkg::*;
#(
  parameter int LANES        = 4,
  parameter bit BOTH_EDGE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] pin_i,
  input  logic [LANES-1:0] irq_mode_i,
  input  logic [LANES-1:0] edge_sel_i,
  input  logic [LANES-1:0] neg_pol_i,
  input  logic [LANES-1:0] both_sel_i,
  input  logic [LANES-1:0] clr_i,
  output logic [LANES-1:0] status_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pid_cfg_t lane_cfg;

    assign lane_cfg.irq_on    = irq_mode_i[g];
    assign lane_cfg.edge_mode = edge_sel_i[g];
    assign lane_cfg.neg_pol   = neg_pol_i[g];
    assign lane_cfg.both_edge = both_sel_i[g];

    pid_lane #(.BOTH_EDGE_EN(BOTH_EDGE_EN)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pin_i[g]),
      .cfg_i    (lane_cfg),
      .clr_i    (clr_i[g]),
      .status_o (status_o[g])
    );
  end

  // R1: reset empties every lane
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (status_o == '0));

endmodule

// File: tb/pin_irq_detect_tb_top.sv
module pin_irq_detect_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int NSTEP      = 29;

  // Fields: irq_mode edge_sel neg_pol both_sel clr pin | expA expB
  // A is built with both-edge, B without. All lanes get the same inputs.
  localparam logic [7:0] TBL [0:NSTEP-1] = '{
    8'b110000_00, // 0 R9 arm edge, rising
    8'b110001_11, // 1 R3 rise sets
    8'b110000_11, // 2 R4 fall, hold
    8'b110010_00, // 3 R5 clear
    8'b110011_11, // 4 R5 rise with clear wins
    8'b110011_00, // 5 R5 clear, steady pin
    8'b111001_00, // 6 R9 polarity flip, no edge
    8'b111000_11, // 7 R3 fall sets in negative
    8'b111011_00, // 8 R3 rise ignored, cleared
    8'b111001_00, // 9 R3 steady
    8'b111101_00, // 10 R9 both-edge on
    8'b111100_11, // 11 R6 fall
    8'b111110_00, // 12 R5 clear
    8'b111101_10, // 13 R6 R7 rise: only A
    8'b111111_00, // 14 R5 clear
    8'b110101_00, // 15 R9 polarity change
    8'b110100_10, // 16 R6 R7 fall: only A
    8'b110110_00, // 17 R5 clear
    8'b100000_00, // 18 R9 level mode
    8'b100001_11, // 19 R8 high active
    8'b100011_11, // 20 R8 clear ignored
    8'b100000_00, // 21 R8 follows low
    8'b101000_00, // 22 R9 negative level
    8'b101000_11, // 23 R8 low active
    8'b101001_00, // 24 R8 inactive
    8'b010000_00, // 25 R2 disarmed
    8'b010001_00, // 26 R2 rise ignored
    8'b110001_00, // 27 R9 arm over high pin
    8'b110001_00  // 28 R9 still quiet
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0] pin = '0, mode = '0, edg = '0, neg = '0, both = '0, clr = '0;
  logic [LANES-1:0] st_a, st_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_detect #(.LANES(LANES), .BOTH_EDGE_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .irq_mode_i(mode), .edge_sel_i(edg),
    .neg_pol_i(neg), .both_sel_i(both), .clr_i(clr), .status_o(st_a));

  pin_irq_detect #(.LANES(LANES), .BOTH_EDGE_EN(1'b0)) dut_nb_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .irq_mode_i(mode), .edge_sel_i(edg),
    .neg_pol_i(neg), .both_sel_i(both), .clr_i(clr), .status_o(st_b));

  task automatic chk(input string req, input logic [LANES-1:0] act,
                     input logic [LANES-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int i);
    if (i == 25 || i == 26) return "R2 disarm";
    if (i >= 18 && i <= 24) return "R8 level";
    if (i >= 10 && i <= 17) return "R6/R7 both-edge";
    if (i == 0 || i == 6 || i >= 27) return "R9 reconfig";
    if (i == 3 || i == 4 || i == 5) return "R5 clear";
    return "R3/R4 edge";
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset A", st_a, '0);
    chk("R1 in reset B", st_b, '0);
    rst_n = 1'b1;

    // Table walk: drive at a falling edge, sample at the next falling edge.
    for (int i = 0; i < NSTEP; i++) begin
      mode = {LANES{TBL[i][7]}};
      edg  = {LANES{TBL[i][6]}};
      neg  = {LANES{TBL[i][5]}};
      both = {LANES{TBL[i][4]}};
      clr  = {LANES{TBL[i][3]}};
      pin  = {LANES{TBL[i][2]}};
      @(negedge clk);
      chk($sformatf("%s step %0d dutA", tag_of(i), i), st_a, {LANES{TBL[i][1]}});
      chk($sformatf("%s step %0d dutB", tag_of(i), i), st_b, {LANES{TBL[i][0]}});
    end

    // R9: reconfiguring clears a latched status
    mode = '1; edg = '1; neg = '0; both = '0; clr = '0; pin = '0;
    repeat (2) @(negedge clk);
    pin = '1;
    @(negedge clk);
    chk("R9 latched before reconfig", st_a, '1);
    neg = '1;
    @(negedge clk);
    chk("R9 reconfig drops latch", st_a, '0);

    // R10: lanes are independent
    neg = '0; pin = '0;
    repeat (2) @(negedge clk);
    pin = 4'b0101;
    @(negedge clk);
    chk("R10 per-lane set", st_a, 4'b0101);
    clr = 4'b0001;
    @(negedge clk);
    chk("R10 per-lane clear", st_a, 4'b0100);
    clr = '0; mode = 4'b1011;
    @(negedge clk);
    chk("R10 disarm one lane", st_b, 4'b0000);

    // R1: reset empties latched status; a high pin at release sets nothing
    mode = '1; pin = '0;
    repeat (2) @(negedge clk);
    pin = '1;
    @(negedge clk);
    chk("R1 latched before reset", st_a, '1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears", st_a, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 release over high pin", st_a, '0);
    @(negedge clk);
    chk("R1 still quiet after release", st_b, '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule